// File: doc/BRIEF.md
# Masked Two-Table Byte Permute Unit

This unit assembles a vector result one byte at a time. Each output lane reads one selector byte from an index vector. That selector picks a byte from one of two lookup tables. Table A is also the destination value, so it is the merge source for masked lanes. Table B is a separate input. Any byte of either table may feed any number of lanes.

The active vector length is chosen per operation: 128, 256 or 512 bits. The length sets how many lanes are produced and how wide the element field of each selector is. A per-lane write mask, which can be disabled, decides which lanes take the selected byte. Each lane whose mask bit is clear is either cleared or keeps its old table A byte, depending on the zeroing input. Everything above the active length is cleared. The result is registered and appears one cycle after the input strobe, together with a valid strobe.

Top module: `dual_table_byte_permute`

## Requirements
- R1: `vl_sel` picks the active length: 0 gives 128 bits (16 lanes), 1 gives 256 bits (32 lanes), 2 or 3 give 512 bits (64 lanes). Lane j occupies result bits [8j+7:8j].
- R2: For lane j the element field of selector byte j (`idx[8j+7:8j]`) is bits [3:0], [4:0] or [5:0] at 128, 256 or 512 bits. The value e of that field picks byte e, which is bits [8e+7:8e], of the chosen table.
- R3: The table-select bit is selector bit 4, 5 or 6 at 128, 256 or 512 bits. A value of 1 picks `table_b` and a value of 0 picks `table_a`.
- R4: Every lane reads table A as it was presented with the operation. A lane written by the same operation never changes what another lane reads.
- R5: When `mask_en` is 0, or the lane's bit of `mask` is 1, an active lane receives the selected byte.
- R6: When `mask_en` is 1, the lane's mask bit is 0 and `zeroing` is 1, the active lane is written with 0x00.
- R7: When `mask_en` is 1, the lane's mask bit is 0 and `zeroing` is 0, the active lane keeps its own `table_a` byte.
- R8: Result bits at and above the active length, up to bit 511, are 0. Mask bits of lanes at or above the active lane count have no effect.
- R9: Selector bits above the table-select bit have no effect on the result.
- R10: Duplicate selector values are legal, and one source byte may appear in any number of lanes.
- R11: `out_valid` is high exactly one cycle after `in_valid`. `result` loads only when `in_valid` is high and holds otherwise. After reset both `result` and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| vl_sel | input | 2 | Active length select |
| mask_en | input | 1 | 1 applies the write mask |
| zeroing | input | 1 | 1 clears masked-off lanes, 0 merges them |
| mask | input | 64 | Per-lane write mask |
| idx | input | 512 | Selector bytes, one per lane |
| table_a | input | 512 | First table and prior destination value |
| table_b | input | 512 | Second table |
| out_valid | output | 1 | Result strobe |
| result | output | 512 | Permuted, masked result |

## Verification
The hardest case to reach from the ports is a lane whose source byte is itself in a lane that the same operation masks off or overwrites. Only that case shows whether every lane reads the original table A. The stimulus reaches it with reversed and duplicated selector patterns drawn from table A, combined with random masks in merge and zeroing modes. Those patterns make masked-off lanes serve as sources for other lanes. Further patterns use selectors with junk above the table-select bit, and 128-bit operations with mask bits set in the inactive lanes. These confirm that bits the unit must ignore do not leak into the result.

// File: rtl/dual_table_byte_permute.sv
module dual_table_byte_permute #(
  parameter int LANES = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [1:0]         vl_sel,
  input  logic               mask_en,
  input  logic               zeroing,
  input  logic [LANES-1:0]   mask,
  input  logic [LANES*8-1:0] idx,
  input  logic [LANES*8-1:0] table_a,
  input  logic [LANES*8-1:0] table_b,
  output logic               out_valid,
  output logic [LANES*8-1:0] result
);
  localparam int W  = LANES * 8;
  localparam int EW = $clog2(LANES);

  logic [EW:0]   n_active;
  logic [EW-1:0] elem_mask;
  logic [2:0]    sel_pos;
  logic [W-1:0]  nxt;

  always_comb begin
    case (vl_sel)
      2'd0:    begin n_active = (EW+1)'(LANES/4); elem_mask = EW'(LANES/4-1); sel_pos = 3'(EW-2); end
      2'd1:    begin n_active = (EW+1)'(LANES/2); elem_mask = EW'(LANES/2-1); sel_pos = 3'(EW-1); end
      default: begin n_active = (EW+1)'(LANES);   elem_mask = EW'(LANES-1);   sel_pos = 3'(EW);   end
    endcase
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [7:0]    s;
    logic [EW-1:0] e;
    logic [7:0]    pick;
    logic          active, wr, unused_top;
    assign s          = idx[8*j +: 8];
    assign e          = s[EW-1:0] & elem_mask;
    assign pick       = s[sel_pos] ? table_b[{e, 3'b000} +: 8] : table_a[{e, 3'b000} +: 8];
    assign active     = (EW+1)'(j) < n_active;
    assign wr         = !mask_en || mask[j];
    assign unused_top = s[7];
    assign nxt[8*j +: 8] = !active ? 8'h00 :
                           wr      ? pick  :
                           zeroing ? 8'h00 : table_a[8*j +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end

  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_no_spurious_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  assert_upper_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vl_sel == 2'd0) |=> result[W-1:W/4] == '0);
  assert_zero_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mask_en && zeroing && !mask[0]) |=> result[7:0] == 8'h00);
  assert_merge_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mask_en && !zeroing && !mask[0]) |=> result[7:0] == $past(table_a[7:0]));
endmodule

// File: tb/test_dual_table_byte_permute.sv
module test_dual_table_byte_permute;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   vl_sel = '0;
  logic         mask_en = 1'b0, zeroing = 1'b0;
  logic [63:0]  mask = '0;
  logic [511:0] idx = '0, table_a = '0, table_b = '0;
  logic         out_valid;
  logic [511:0] result;
  int n_chk = 0, n_bad = 0;
  logic [31:0] rs = 32'h1234_5678;

  always #4 clk = ~clk;

  dual_table_byte_permute i_dual_table_byte_permute (
    .clk, .rst_n, .in_valid, .vl_sel, .mask_en, .zeroing, .mask,
    .idx, .table_a, .table_b, .out_valid, .result);

  // {vl[15:14], mask_en[13], zeroing[12], pattern[11:8], seed[7:0]}
  localparam logic [15:0] VEC [14] = '{
    16'h0000 | 16'h0011, 16'h4000 | 16'h0022, 16'h8000 | 16'h0033,
    16'h2000 | 16'h0144, 16'h7000 | 16'h0155, 16'hA000 | 16'h0266,
    16'h3000 | 16'h0277, 16'hE000 | 16'h0388, 16'h2000 | 16'h0399,
    16'h6000 | 16'h04AA, 16'hB000 | 16'h04BB, 16'hF000 | 16'h00CC,
    16'h3000 | 16'h01DD, 16'hA000 | 16'h03EE };

  function automatic logic [31:0] nxt_rand(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  task automatic rnd512(output logic [511:0] v);
    for (int k = 0; k < 16; k++) begin rs = nxt_rand(rs); v[32*k +: 32] = rs; end
  endtask

  function automatic logic [511:0] model(input logic [511:0] a, input logic [511:0] ix,
      input logic [511:0] b, input logic [63:0] m, input logic me, input logic z,
      input logic [1:0] vl);
    logic [511:0] r = '0;
    int n = (vl == 0) ? 16 : (vl == 1) ? 32 : 64;
    int tbit = (vl == 0) ? 4 : (vl == 1) ? 5 : 6;
    for (int j = 0; j < n; j++) begin
      int e = int'(ix[8*j +: 8]) % n;
      logic [7:0] p = ix[8*j + tbit] ? b[8*e +: 8] : a[8*e +: 8];
      if (!me || m[j]) r[8*j +: 8] = p;
      else if (z)      r[8*j +: 8] = 8'h00;
      else             r[8*j +: 8] = a[8*j +: 8];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [511:0] got, input logic [511:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic run_op(input string tag);
    logic [511:0] exp = model(table_a, idx, table_b, mask, mask_en, zeroing, vl_sel);
    @(negedge clk) in_valid = 1'b1;
    @(negedge clk) in_valid = 1'b0;
    check({tag, " R11 valid"}, {511'b0, out_valid}, 512'd1);
    check(tag, result, exp);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog R11 got timeout exp completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    logic [511:0] keep;
    repeat (3) @(negedge clk);
    check("R11 reset result", result, '0);
    check("R11 reset valid", {511'b0, out_valid}, '0);
    rst_n = 1'b1;

    foreach (VEC[v]) begin
      int n, tb;
      string tag;
      vl_sel = VEC[v][15:14]; mask_en = VEC[v][13]; zeroing = VEC[v][12];
      rs = {24'h5a5a5a, VEC[v][7:0]};
      n  = (vl_sel == 0) ? 16 : (vl_sel == 1) ? 32 : 64;
      tb = (vl_sel == 0) ? 4 : (vl_sel == 1) ? 5 : 6;
      rnd512(table_a); rnd512(table_b); rnd512(idx); mask = {table_b[63:32], idx[31:0]} ^ 64'h0f0f_3c3c_a5a5_9669;
      case (VEC[v][11:8])
        4'd1: begin for (int j = 1; j < 64; j++) idx[8*j +: 8] = idx[7:0]; tag = "R10 duplicates"; end
        4'd2: begin for (int j = 0; j < 64; j++) idx[8*j + tb] = 1'b1; tag = "R3 all table B"; end
        4'd3: begin for (int j = 0; j < 64; j++) begin
                idx[8*j +: 8] = 8'(n - 1 - (j % n)) | 8'hC0 & ~(8'(1) << tb); end
              tag = "R4 reversed A"; end
        4'd4: begin for (int j = 0; j < 64; j++) idx[8*j +: 8] = 8'((j + 1) % n);
              tag = "R4 rotated A"; end
        default: tag = "R1 R2 R3 random";
      endcase
      tag = {tag, !mask_en ? " R5" : zeroing ? " R6" : " R7"};
      run_op(tag);
    end

    vl_sel = 2'd0; mask_en = 1'b1; zeroing = 1'b0; mask = 64'hFFFF_FFFF_FFFF_0000;
    rnd512(table_a); rnd512(table_b);
    for (int j = 0; j < 64; j++) idx[8*j +: 8] = 8'hE0 | 8'(j & 15);
    run_op("R8 R7 R9 upper mask bits ignored");
    check("R8 upper cleared", {128'b0, result[511:128]}, '0);
    check("R7 merge keeps A", {384'b0, result[127:0]}, {384'b0, table_a[127:0]});

    vl_sel = 2'd3; mask_en = 1'b0;
    for (int j = 0; j < 64; j++) idx[8*j +: 8] = 8'hC0 | 8'(63 - j);
    run_op("R1 R9 R2 length 3 as 512, bit7 junk");
    check("R3 R9 reverse of B", result, {<<8{table_b}});

    vl_sel = 2'd1; mask_en = 1'b1; zeroing = 1'b1; mask = '0;
    run_op("R6 all zero");
    check("R6 R8 all cleared", result, '0);

    keep = result;
    rnd512(table_a); rnd512(idx); mask = '1;
    repeat (4) @(negedge clk);
    check("R11 hold while idle", result, keep);
    check("R11 valid low while idle", {511'b0, out_valid}, '0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule